// File: doc/BRIEF.md
# Staircase Multilevel Gate Encoder

This block drives the twelve gate signals of a chain of three series-connected H-bridges. The bridges sit on DC sources weighted 4, 2 and 1 per unit, so their outputs add up to fifteen distinct voltage steps from -7 to +7 per unit. A controller presents one signed, sampled sinusoidal reference together with a one-cycle sample strobe at a fixed rate, nominally 16 kHz. On each strobe the block reduces the reference to a magnitude and counts how many of seven ascending magnitude thresholds it reaches. That count is the step size, and the sign of the reference is its polarity.

The chosen step is split into its binary weights. Every bridge whose weight is present is driven at the step's polarity, and every other bridge is held in its freewheeling zero state. A bridge never opposes the others to make up a level. The thresholds come from the arcsine switching-angle rule with tuning coefficient k = 0.5. Because the reference is compared in magnitude space, the threshold for step n is (n - 0.5)/7 of full scale. Software may overwrite these thresholds through a small register port, which also holds a break-before-make dead count. Each leg is built as a break-before-make half-bridge, so whenever a leg changes side, both of its switches are held off before the new one turns on.

Top module: `mlg_stair_enc`

## Requirements
- R1: A synchronous reset drives all gates low and `level_o` to 0. It reloads threshold n (n = 1..7) with floor(((2n-1)*32767 + 7)/14) and reloads the dead count with 4. Gates stay low until the first sample strobe. The first pattern appears on the second clock edge after that strobe.
- R2: On the clock edge that samples `smp_valid_i`, `level_o` takes the number of thresholds t_n for which |ref| >= t_n, with the sign of the reference. Equality counts as reached. Between strobes `level_o` holds its value.
- R3: A negative reference is compared on its absolute value against the same thresholds. The most negative code, -32768, gives level -7.
- R4: Bridge b (b = 0, 1, 2) has weight 2^b and drives `gate_o[4b+3:4b]`. It is active exactly when bit b of |level| is set, so the active weights sum to |level|.
- R5: Inside a bridge slice, bit 0 is the left upper switch, bit 1 the left lower, bit 2 the right upper and bit 3 the right lower. The +1 state turns on bits 0 and 3 (1001). The -1 state turns on bits 1 and 2 (0110). The zero state turns on both lower switches (1010).
- R6: Every active bridge takes the sign of the level, and a positive bridge and a negative bridge never coexist. Level 0 puts all three bridges in the zero state (gate_o = 0xAAA).
- R7: The upper and lower switch of one leg are never on in the same cycle.
- R8: When a leg must change side, it turns both its switches off on the next edge. It holds them off for exactly D+1 cycles, where D is the dead count latched at that edge, and then turns on the side that the current level calls for. Legs that need no change keep their switch on.
- R9: A write with `cfg_addr_i` 0..6 loads threshold addr+1 from `cfg_wdata_i`. Address 7 loads the dead count from the low 8 bits. A strobe in the same cycle as a write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid_i | input | 1 | One-cycle sample strobe |
| smp_ref_i | input | 16 | Signed sampled reference |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register address (0..6 thresholds, 7 dead count) |
| cfg_wdata_i | input | 16 | Register write data |
| level_o | output | 4 | Signed selected level, -7..+7 |
| gate_o | output | 12 | Gate drives, four per bridge |

## Verification
The bench targets the threshold edges: a reference exactly on a threshold, one code below it, full scale, and the most negative code. A design that compared strictly, or took the absolute value in too few bits, would land one step low or wrap to level 0. It measures the off window of a leg for dead counts of 4, 2 and 0, and it changes the level in the middle of a dead window. An off-by-one counter would show up as a window one cycle long or short. A design that lost the retarget would leave a bridge on the wrong side. A threshold write that shares a cycle with a strobe exposes a design that compares against the freshly written value, and the quiet cycles after reset catch gates that leave the all-off state before the first strobe.

// File: rtl/mlg_pkg.sv
package mlg_pkg;
   // Drive state of one half-bridge leg
   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_HI  = 2'd1,
      LEG_LO  = 2'd2
   } leg_drv_e;
endpackage

// File: rtl/mlg_cfg_regs.sv
module mlg_cfg_regs #(
   parameter int REF_W     = 16,
   parameter int N_STEPS   = 7,
   parameter int ADDR_W    = 3,
   parameter int DT_W      = 8,
   parameter int DEAD_INIT = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            we_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [REF_W-1:0]                wdata_i,
   output logic [N_STEPS-1:0][REF_W-1:0]   thr_o,
   output logic [DT_W-1:0]                 dead_o
);
   // Threshold n sits at (n - 0.5)/N_STEPS of positive full scale
   function automatic logic [REF_W-1:0] thr_default(int n);
      longint fs;
      longint v;
      fs = (longint'(1) << (REF_W - 1)) - 1;
      v  = ((longint'(2 * n - 1) * fs) + longint'(N_STEPS)) / longint'(2 * N_STEPS);
      return REF_W'(v);
   endfunction

   logic [N_STEPS-1:0][REF_W-1:0] thr_q;
   logic [DT_W-1:0]               dead_q;

   generate
      for (genvar i = 0; i < N_STEPS; i++) begin : g_thr
         localparam logic [REF_W-1:0] THR_RST = thr_default(i + 1);
         always_ff @(posedge clk) begin
            if (rst) begin
               thr_q[i] <= THR_RST;
            end else if (we_i && (addr_i == ADDR_W'(i))) begin
               thr_q[i] <= wdata_i;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         dead_q <= DT_W'(DEAD_INIT);
      end else if (we_i && (addr_i == ADDR_W'(N_STEPS))) begin
         dead_q <= wdata_i[DT_W-1:0];
      end
   end

   assign thr_o  = thr_q;
   assign dead_o = dead_q;
endmodule

// File: rtl/mlg_zone_sel.sv
module mlg_zone_sel #(
   parameter int REF_W     = 16,
   parameter int N_STEPS   = 7,
   parameter int CNT_W     = 3,
   parameter bit INCLUSIVE = 1'b1
) (
   input  logic signed [REF_W-1:0]        ref_i,
   input  logic [N_STEPS-1:0][REF_W-1:0]  thr_i,
   output logic signed [CNT_W:0]          level_o
);
   logic [REF_W-1:0]   ref_u;
   logic [REF_W-1:0]   mag;
   logic [N_STEPS-1:0] hit;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W:0]     ext;
   logic               neg;

   assign ref_u = ref_i;
   // Full-width magnitude: the most negative code maps to 2^(REF_W-1)
   assign mag   = ref_u[REF_W-1] ? (~ref_u + 1'b1) : ref_u;

   generate
      if (INCLUSIVE) begin : g_incl
         for (genvar i = 0; i < N_STEPS; i++) begin : g_cmp
            assign hit[i] = (mag >= thr_i[i]);
         end
      end else begin : g_excl
         for (genvar i = 0; i < N_STEPS; i++) begin : g_cmp
            assign hit[i] = (mag > thr_i[i]);
         end
      end
   endgenerate

   always_comb begin
      cnt = '0;
      for (int i = 0; i < N_STEPS; i++) begin
         cnt = cnt + CNT_W'(hit[i]);
      end
   end

   assign ext     = {1'b0, cnt};
   assign neg     = ref_u[REF_W-1] && (cnt != '0);
   assign level_o = neg ? (~ext + 1'b1) : ext;
endmodule

// File: rtl/mlg_leg_dt.sv
module mlg_leg_dt
   import mlg_pkg::*;
#(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en_i,
   input  leg_drv_e        tgt_i,
   input  logic [DT_W-1:0] dead_i,
   output leg_drv_e        drv_o
);
   leg_drv_e        cur_q;
   logic [DT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= LEG_OFF;
         cnt_q <= '0;
      end else if (en_i) begin
         if (cur_q != LEG_OFF) begin
            // Break first: any change of side passes through off
            if (tgt_i != cur_q) begin
               cur_q <= LEG_OFF;
               cnt_q <= dead_i;
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            cur_q <= tgt_i;
         end
      end
   end

   assign drv_o = cur_q;
endmodule

// File: rtl/mlg_stair_enc.sv
module mlg_stair_enc
   import mlg_pkg::*;
#(
   parameter int  N_BRIDGE  = 3,
   parameter int  REF_W     = 16,
   parameter int  DT_W      = 8,
   parameter int  DEAD_INIT = 4,
   parameter bit  INCLUSIVE = 1'b1,
   localparam int N_STEPS   = (1 << N_BRIDGE) - 1,
   localparam int LVL_W     = N_BRIDGE + 1,
   localparam int ADDR_W    = $clog2(N_STEPS + 1),
   localparam int N_GATE    = 4 * N_BRIDGE
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_valid_i,
   input  logic signed [REF_W-1:0] smp_ref_i,
   input  logic                    cfg_we_i,
   input  logic [ADDR_W-1:0]       cfg_addr_i,
   input  logic [REF_W-1:0]        cfg_wdata_i,
   output logic signed [LVL_W-1:0] level_o,
   output logic [N_GATE-1:0]       gate_o
);
   // Elaboration-time parameter checks
   generate
      if (N_BRIDGE < 1 || N_BRIDGE > 4) begin : g_bad_nb
         $error("N_BRIDGE must be within 1..4");
      end
      if (REF_W < N_BRIDGE + 3 || REF_W > 30) begin : g_bad_refw
         $error("REF_W out of supported range");
      end
      if (DT_W < 1 || DT_W > REF_W) begin : g_bad_dtw
         $error("DT_W must be within 1..REF_W");
      end
      if (DEAD_INIT < 0 || DEAD_INIT >= (1 << DT_W)) begin : g_bad_dead
         $error("DEAD_INIT does not fit DT_W");
      end
   endgenerate

   logic [N_STEPS-1:0][REF_W-1:0] thr;
   logic [DT_W-1:0]               dead;
   logic signed [LVL_W-1:0]       lvl_d;
   logic signed [LVL_W-1:0]       level_q;
   logic                          armed_q;
   logic                          lvl_neg;
   logic [N_BRIDGE-1:0]           lvl_mag;

   mlg_cfg_regs #(
      .REF_W    (REF_W),
      .N_STEPS  (N_STEPS),
      .ADDR_W   (ADDR_W),
      .DT_W     (DT_W),
      .DEAD_INIT(DEAD_INIT)
   ) u_cfg (
      .clk    (clk),
      .rst    (rst),
      .we_i   (cfg_we_i),
      .addr_i (cfg_addr_i),
      .wdata_i(cfg_wdata_i),
      .thr_o  (thr),
      .dead_o (dead)
   );

   mlg_zone_sel #(
      .REF_W    (REF_W),
      .N_STEPS  (N_STEPS),
      .CNT_W    (N_BRIDGE),
      .INCLUSIVE(INCLUSIVE)
   ) u_zone (
      .ref_i  (smp_ref_i),
      .thr_i  (thr),
      .level_o(lvl_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
         armed_q <= 1'b0;
      end else if (smp_valid_i) begin
         level_q <= lvl_d;
         armed_q <= 1'b1;
      end
   end

   assign lvl_neg = level_q[LVL_W-1];
   assign lvl_mag = lvl_neg ? (~level_q[N_BRIDGE-1:0] + 1'b1) : level_q[N_BRIDGE-1:0];

   generate
      for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
         leg_drv_e tgt_a;
         leg_drv_e tgt_b;
         leg_drv_e drv_a;
         leg_drv_e drv_b;

         // Inactive bridge freewheels on both lower switches
         always_comb begin
            tgt_a = LEG_LO;
            tgt_b = LEG_LO;
            if (lvl_mag[b]) begin
               if (lvl_neg) begin
                  tgt_b = LEG_HI;
               end else begin
                  tgt_a = LEG_HI;
               end
            end
         end

         mlg_leg_dt #(.DT_W(DT_W)) u_leg_a (
            .clk   (clk),
            .rst   (rst),
            .en_i  (armed_q),
            .tgt_i (tgt_a),
            .dead_i(dead),
            .drv_o (drv_a)
         );

         mlg_leg_dt #(.DT_W(DT_W)) u_leg_b (
            .clk   (clk),
            .rst   (rst),
            .en_i  (armed_q),
            .tgt_i (tgt_b),
            .dead_i(dead),
            .drv_o (drv_b)
         );

         assign gate_o[4*b+0] = (drv_a == LEG_HI);
         assign gate_o[4*b+1] = (drv_a == LEG_LO);
         assign gate_o[4*b+2] = (drv_b == LEG_HI);
         assign gate_o[4*b+3] = (drv_b == LEG_LO);
      end
   endgenerate

   assign level_o = level_q;
endmodule

// File: rtl/mlg_stair_enc_chk.sv
module mlg_stair_enc_chk #(
   parameter int  N_BRIDGE = 3,
   localparam int LVL_W    = N_BRIDGE + 1,
   localparam int N_GATE   = 4 * N_BRIDGE
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    smp_valid_i,
   input logic signed [LVL_W-1:0] level_o,
   input logic [N_GATE-1:0]       gate_o
);
   logic [N_BRIDGE-1:0] br_pos;
   logic [N_BRIDGE-1:0] br_neg;

   generate
      for (genvar b = 0; b < N_BRIDGE; b++) begin : g_b
         assign br_pos[b] = gate_o[4*b+0] & gate_o[4*b+3];
         assign br_neg[b] = gate_o[4*b+1] & gate_o[4*b+2];

         assert_leg_a_excl_R7: assert property (@(posedge clk) disable iff (rst)
            !(gate_o[4*b+0] && gate_o[4*b+1]));
         assert_leg_b_excl_R7: assert property (@(posedge clk) disable iff (rst)
            !(gate_o[4*b+2] && gate_o[4*b+3]));

         // A leg never moves between its switches without an off cycle
         assert_leg_a_lo_break_R8: assert property (@(posedge clk) disable iff (rst)
            gate_o[4*b+1] |-> !$past(gate_o[4*b+0]));
         assert_leg_a_hi_break_R8: assert property (@(posedge clk) disable iff (rst)
            gate_o[4*b+0] |-> !$past(gate_o[4*b+1]));
         assert_leg_b_lo_break_R8: assert property (@(posedge clk) disable iff (rst)
            gate_o[4*b+3] |-> !$past(gate_o[4*b+2]));
         assert_leg_b_hi_break_R8: assert property (@(posedge clk) disable iff (rst)
            gate_o[4*b+2] |-> !$past(gate_o[4*b+3]));
      end
   endgenerate

   assert_same_polarity_R6: assert property (@(posedge clk) disable iff (rst)
      !((br_pos != '0) && (br_neg != '0)));

   assert_reset_off_R1: assert property (@(posedge clk)
      rst |=> ((gate_o == '0) && (level_o == '0)));

   assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(smp_valid_i) |-> $stable(level_o));

   assert_level_range_R2: assert property (@(posedge clk) disable iff (rst)
      level_o != {1'b1, {N_BRIDGE{1'b0}}});
endmodule

bind mlg_stair_enc mlg_stair_enc_chk #(.N_BRIDGE(N_BRIDGE)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .smp_valid_i(smp_valid_i),
   .level_o    (level_o),
   .gate_o     (gate_o)
);

// File: tb/mlg_stair_enc_bench.sv
module mlg_stair_enc_bench;
   localparam int NB     = 3;
   localparam int NS     = 7;
   localparam int NL     = 2 * NB;
   localparam int DT_DEF = 4;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               smp_valid = 1'b0;
   logic signed [15:0] smp_ref = '0;
   logic               cfg_we = 1'b0;
   logic [2:0]         cfg_addr = '0;
   logic [15:0]        cfg_wdata = '0;
   logic signed [3:0]  level;
   logic [11:0]        gate;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   bit    cmp_en  = 1'b0;
   string phase   = "R1";

   always #10 clk = ~clk;

   mlg_stair_enc u_mlg_stair_enc (
      .clk        (clk),
      .rst        (rst),
      .smp_valid_i(smp_valid),
      .smp_ref_i  (smp_ref),
      .cfg_we_i   (cfg_we),
      .cfg_addr_i (cfg_addr),
      .cfg_wdata_i(cfg_wdata),
      .level_o    (level),
      .gate_o     (gate)
   );

   // ---------------- behavioural reference model ----------------
   int m_thr [NS];
   int m_dead;
   int m_lvl;
   bit m_armed;
   int m_cur [NL];   // 0 off, 1 upper on, 2 lower on
   int m_cnt [NL];

   function automatic int thr_def(int n);
      return ((2 * n - 1) * 32767 + 7) / 14;
   endfunction

   function automatic int leg_want(int lv, int br, int side);
      int m;
      m = (lv < 0) ? -lv : lv;
      if (((m >> br) & 1) == 0) return 2;
      if (side == 0) return (lv > 0) ? 1 : 2;
      return (lv < 0) ? 1 : 2;
   endfunction

   function automatic logic [11:0] model_gate();
      logic [11:0] g;
      g = '0;
      for (int l = 0; l < NL; l++) begin
         if (m_cur[l] == 1) g[2 * l]     = 1'b1;
         if (m_cur[l] == 2) g[2 * l + 1] = 1'b1;
      end
      return g;
   endfunction

   function automatic logic [11:0] pat(int lv);
      logic [11:0] g;
      int m;
      m = (lv < 0) ? -lv : lv;
      for (int b = 0; b < NB; b++) begin
         if (((m >> b) & 1) == 0)  g[4*b +: 4] = 4'b1010;
         else if (lv > 0)          g[4*b +: 4] = 4'b1001;
         else                      g[4*b +: 4] = 4'b0110;
      end
      return g;
   endfunction

   always @(posedge clk) begin
      int t;
      int mag;
      int c;
      if (rst) begin
         for (int i = 0; i < NS; i++) m_thr[i] = thr_def(i + 1);
         m_dead  = DT_DEF;
         m_lvl   = 0;
         m_armed = 1'b0;
         for (int l = 0; l < NL; l++) begin
            m_cur[l] = 0;
            m_cnt[l] = 0;
         end
      end else begin
         if (m_armed) begin
            for (int l = 0; l < NL; l++) begin
               t = leg_want(m_lvl, l / 2, l % 2);
               if (m_cur[l] != 0) begin
                  if (m_cur[l] != t) begin
                     m_cur[l] = 0;
                     m_cnt[l] = m_dead;
                  end
               end else if (m_cnt[l] > 0) begin
                  m_cnt[l] = m_cnt[l] - 1;
               end else begin
                  m_cur[l] = t;
               end
            end
         end
         if (smp_valid) begin
            mag = (smp_ref < 0) ? -int'(smp_ref) : int'(smp_ref);
            c = 0;
            for (int i = 0; i < NS; i++) if (mag >= m_thr[i]) c++;
            m_lvl   = (smp_ref < 0) ? -c : c;
            m_armed = 1'b1;
         end
         if (cfg_we) begin
            if (cfg_addr < 3'd7) m_thr[cfg_addr] = int'(cfg_wdata);
            else                 m_dead = int'(cfg_wdata) & 255;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(gate == model_gate(), phase, "gate vs model", int'(gate), int'(model_gate()));
         chk(int'(level) == m_lvl, phase, "level vs model", int'(level), m_lvl);
         for (int b = 0; b < NB; b++) begin
            chk(!(gate[4*b] && gate[4*b+1]) && !(gate[4*b+2] && gate[4*b+3]),
                "R7", "leg exclusion", int'(gate), 0);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick(int r);
      smp_valid = 1'b1;
      smp_ref   = 16'(r);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic cfg_write(int a, int d);
      cfg_we    = 1'b1;
      cfg_addr  = 3'(a);
      cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic write_and_tick(int a, int d, int r);
      cfg_we    = 1'b1;
      cfg_addr  = 3'(a);
      cfg_wdata = 16'(d);
      smp_valid = 1'b1;
      smp_ref   = 16'(r);
      @(negedge clk);
      cfg_we    = 1'b0;
      smp_valid = 1'b0;
   endtask

   task automatic measure_off(int exp_cycles, string req);
      int off_cnt;
      bit seen;
      off_cnt = 0;
      seen    = 1'b0;
      for (int k = 0; k < 40; k++) begin
         if (gate[3:0] == 4'b0000) begin
            off_cnt++;
            seen = 1'b1;
         end else if (seen) begin
            break;
         end
         @(negedge clk);
      end
      chk(off_cnt == exp_cycles, req, "bridge0 off cycles", off_cnt, exp_cycles);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      cyc(3);
      rst = 1'b0;
      chk(gate == 12'h000, "R1", "gates after reset", int'(gate), 0);
      chk(level == 4'sd0, "R1", "level after reset", int'(level), 0);
      cmp_en = 1'b1;
      cyc(5);
      chk(gate == 12'h000, "R1", "gates before first strobe", int'(gate), 0);

      // first strobe exactly on threshold 1
      phase = "R2";
      tick(thr_def(1));
      chk(int'(level) == 1, "R2", "level on threshold 1", int'(level), 1);
      chk(gate == 12'h000, "R1", "gates one edge after first strobe", int'(gate), 0);
      cyc(1);
      chk(gate == pat(1), "R1", "first pattern", int'(gate), int'(pat(1)));
      tick(thr_def(1) - 1);
      chk(int'(level) == 0, "R2", "one code below threshold 1", int'(level), 0);
      cyc(12);
      chk(gate == 12'hAAA, "R6", "zero state", int'(gate), 12'hAAA);
      tick(thr_def(7));
      chk(int'(level) == 7, "R2", "level on threshold 7", int'(level), 7);
      tick(32767);
      chk(int'(level) == 7, "R2", "full scale", int'(level), 7);
      cyc(12);

      // positive sweep
      phase = "R4";
      for (int lv = 1; lv <= 7; lv++) begin
         tick(thr_def(lv) + 3);
         cyc(12);
         chk(int'(level) == lv, "R4", "positive level", int'(level), lv);
         chk(gate == pat(lv), "R5", "positive pattern", int'(gate), int'(pat(lv)));
      end

      // negative sweep
      phase = "R3";
      for (int lv = 1; lv <= 7; lv++) begin
         tick(-(thr_def(lv) + 3));
         cyc(12);
         chk(int'(level) == -lv, "R3", "negative level", int'(level), -lv);
         chk(gate == pat(-lv), "R6", "negative pattern", int'(gate), int'(pat(-lv)));
      end
      tick(-32768);
      chk(int'(level) == -7, "R3", "most negative code", int'(level), -7);
      tick(0);
      cyc(12);
      chk(gate == 12'hAAA, "R6", "zero after negative", int'(gate), 12'hAAA);

      // dead time: default 4, then 2, then 0
      phase = "R8";
      tick(thr_def(1) + 3);
      cyc(12);
      tick(-(thr_def(1) + 3));
      measure_off(DT_DEF + 1, "R8");
      cfg_write(7, 2);
      tick(thr_def(1) + 3);
      measure_off(3, "R8");
      cyc(10);
      chk(gate == pat(1), "R8", "settled after dead 2", int'(gate), int'(pat(1)));
      cfg_write(7, 0);
      tick(-(thr_def(1) + 3));
      measure_off(1, "R8");
      cyc(6);
      // retarget in the middle of a dead window
      cfg_write(7, 6);
      tick(thr_def(1) + 3);
      cyc(3);
      tick(-(thr_def(1) + 3));
      cyc(16);
      chk(gate == pat(-1), "R8", "retarget during dead time", int'(gate), int'(pat(-1)));

      // register port
      phase = "R9";
      cfg_write(0, 100);
      tick(150);
      chk(int'(level) == 1, "R9", "written threshold reached", int'(level), 1);
      tick(99);
      chk(int'(level) == 0, "R9", "written threshold missed", int'(level), 0);
      write_and_tick(0, 5000, 3000);
      chk(int'(level) == 1, "R9", "strobe with write uses old value", int'(level), 1);
      tick(3000);
      chk(int'(level) == 0, "R9", "new threshold after write", int'(level), 0);
      cyc(20);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule